// File: doc/BRIEF.md
# Console Device Register Window

This block sits between a 16-bit processor's memory bus and its RAM and claims five fixed addresses as console device registers. A keyboard side supplies characters through a strobe, and a display side receives characters through a strobe and answers with an accept pulse. A control register carries the run enable that lets the processor keep executing instructions. Every other address is forwarded untouched to the RAM port.

The keyboard status register has a side effect on read. Each read samples a one-deep holding slot that catches characters arriving on the strobe. If the slot is full, the read reports bit 15 set, moves the character into the keyboard data register and empties the slot. If the slot is empty, the read reports zero. The display data register sends its low byte to the display only when the display is ready. The display then stays busy until the accept pulse arrives. Read data for both device and RAM accesses appears on the cycle after the request.

Top module: `conio_regs`

## Requirements
- R1: After reset, run_en is 1, the machine control register reads 0x8000, the display status register reads 0x8000, the keyboard status register reads 0x0000 and disp_stb is low.
- R2: Only the exact addresses 0xFE00, 0xFE02, 0xFE04, 0xFE06 and 0xFFFE are device registers. For any other address, ram_req follows bus_req in the same cycle, and ram_we, ram_addr and ram_wdata follow the bus. For a device address, ram_req stays low. Read data of any access is on bus_rdata one cycle after the request.
- R3: A key_stb with a nonzero key_char fills the holding slot, and a later strobe overwrites an earlier one. A key_stb with a zero key_char is ignored.
- R4: A read of 0xFE00 returns 0x8000 when the slot is full, copies the slot character into the keyboard data register and empties the slot. When the slot is empty, the read returns 0x0000.
- R5: A read of 0xFE02 returns the latched character in bits 7:0 and zero above. This read has no side effect, so repeated reads give the same value.
- R6: When a strobe and a read of 0xFE00 fall in the same cycle, the read reports and consumes the slot as it was before that cycle. The new character stays pending for the next status read.
- R7: A read of 0xFE04 returns 0x8000 while the display is ready and 0x0000 while it is busy.
- R8: A write to 0xFE06 while the display is ready gives a one-cycle disp_stb on the next cycle, with disp_char equal to the written bits 7:0, and makes the display busy. A write while busy produces no strobe. disp_ack makes the display ready from the following cycle, but a write that is accepted in the same cycle takes precedence.
- R9: Bit 15 of a write to 0xFFFE sets run_en from the next cycle. A read of 0xFFFE returns run_en in bit 15 and zero in all other bits.
- R10: Writes to 0xFE00, 0xFE02 and 0xFE04 change nothing, and a read of 0xFE06 returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| ram_req | output | 1 | Forwarded request to RAM |
| ram_we | output | 1 | Forwarded write flag |
| ram_addr | output | 16 | Forwarded address |
| ram_wdata | output | 16 | Forwarded write data |
| ram_rdata | input | 16 | RAM read data, one cycle after ram_req |
| key_stb | input | 1 | Keyboard character strobe |
| key_char | input | 8 | Keyboard character |
| disp_ack | input | 1 | Display has taken the character |
| disp_stb | output | 1 | Character strobe to display |
| disp_char | output | 8 | Character to display |
| run_en | output | 1 | Processor run enable |

## Verification
Two events can fall in the same cycle. A keyboard strobe can meet a status read that drains the holding slot, and a display accept can meet a new display write. The bench provokes both on purpose, first with a directed strobe issued in the same cycle as a 0xFE00 read and a write to 0xFE06 issued together with disp_ack, and then with a long run of mixed random traffic. It judges each case against a behavioural model that applies the read before the strobe and gives the accepted write precedence over the ack, and it compares read data, strobes and run_en on every clock.

// File: rtl/conio_pkg.sv
package conio_pkg;
  typedef enum logic [2:0] {
    SEL_RAM,
    SEL_KSTAT,
    SEL_KDATA,
    SEL_DSTAT,
    SEL_DDATA,
    SEL_MCTL
  } csel_e;
endpackage

// File: rtl/cr_decode.sv
module cr_decode
  import conio_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] A_KS = 16'hFE00,
  parameter logic [AW-1:0] A_KD = 16'hFE02,
  parameter logic [AW-1:0] A_DS = 16'hFE04,
  parameter logic [AW-1:0] A_DD = 16'hFE06,
  parameter logic [AW-1:0] A_MC = 16'hFFFE
) (
  input  logic [AW-1:0] addr,
  output csel_e         sel
);
  always_comb begin
    unique case (addr)
      A_KS:    sel = SEL_KSTAT;
      A_KD:    sel = SEL_KDATA;
      A_DS:    sel = SEL_DSTAT;
      A_DD:    sel = SEL_DDATA;
      A_MC:    sel = SEL_MCTL;
      default: sel = SEL_RAM;
    endcase
  end
endmodule

// File: rtl/cr_kbd.sv
module cr_kbd #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_stb,
  input  logic [CW-1:0] key_char,
  input  logic          sample,
  output logic          pend_o,
  output logic [CW-1:0] kdata_o
);
  logic          pend_q;
  logic [CW-1:0] pchar_q;
  logic [CW-1:0] kdata_q;
  logic          fill;

  assign fill = key_stb && (key_char != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      pchar_q <= '0;
      kdata_q <= '0;
    end else begin
      if (sample && pend_q) kdata_q <= pchar_q;
      if (fill) begin
        pend_q  <= 1'b1;
        pchar_q <= key_char;
      end else if (sample) begin
        pend_q  <= 1'b0;
      end
    end
  end

  assign pend_o  = pend_q;
  assign kdata_o = kdata_q;
endmodule

// File: rtl/cr_disp.sv
module cr_disp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] wchar,
  input  logic          ack,
  output logic          ready_o,
  output logic          stb_o,
  output logic [CW-1:0] char_o
);
  logic          ready_q;
  logic          stb_q;
  logic [CW-1:0] char_q;
  logic          take;

  assign take = wr && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b1;
      stb_q   <= 1'b0;
      char_q  <= '0;
    end else begin
      stb_q <= take;
      if (take) begin
        char_q  <= wchar;
        ready_q <= 1'b0;
      end else if (ack) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign ready_o = ready_q;
  assign stb_o   = stb_q;
  assign char_o  = char_q;
endmodule

// File: rtl/conio_regs.sv
module conio_regs
  import conio_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter logic [AW-1:0] A_KS = 16'hFE00,
  parameter logic [AW-1:0] A_KD = 16'hFE02,
  parameter logic [AW-1:0] A_DS = 16'hFE04,
  parameter logic [AW-1:0] A_DD = 16'hFE06,
  parameter logic [AW-1:0] A_MC = 16'hFFFE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          ram_req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata,
  input  logic          key_stb,
  input  logic [CW-1:0] key_char,
  input  logic          disp_ack,
  output logic          disp_stb,
  output logic [CW-1:0] disp_char,
  output logic          run_en
);
  localparam int TOP = DW - 1;
  localparam logic [DW-1:0] FLAG = DW'(1) << TOP;

  csel_e         sel;
  logic          rd, wr, is_dev;
  logic          pend;
  logic [CW-1:0] kdata;
  logic          dready;
  logic          run_q;
  logic [DW-1:0] rval;
  logic [DW-1:0] dev_q;
  logic          devrd_q;

  cr_decode #(.AW(AW), .A_KS(A_KS), .A_KD(A_KD), .A_DS(A_DS), .A_DD(A_DD), .A_MC(A_MC))
    u_dec (.addr(bus_addr), .sel(sel));

  assign rd     = bus_req && !bus_we;
  assign wr     = bus_req && bus_we;
  assign is_dev = (sel != SEL_RAM);

  cr_kbd #(.CW(CW)) u_kbd (
    .clk(clk), .rst(rst), .key_stb(key_stb), .key_char(key_char),
    .sample(rd && sel == SEL_KSTAT), .pend_o(pend), .kdata_o(kdata)
  );

  cr_disp #(.CW(CW)) u_disp (
    .clk(clk), .rst(rst), .wr(wr && sel == SEL_DDATA), .wchar(bus_wdata[CW-1:0]),
    .ack(disp_ack), .ready_o(dready), .stb_o(disp_stb), .char_o(disp_char)
  );

  always_comb begin
    unique case (sel)
      SEL_KSTAT: rval = pend   ? FLAG : '0;
      SEL_KDATA: rval = {{(DW-CW){1'b0}}, kdata};
      SEL_DSTAT: rval = dready ? FLAG : '0;
      SEL_MCTL:  rval = run_q  ? FLAG : '0;
      default:   rval = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b1;
      dev_q   <= '0;
      devrd_q <= 1'b0;
    end else begin
      if (wr && sel == SEL_MCTL) run_q <= bus_wdata[TOP];
      devrd_q <= rd && is_dev;
      if (rd && is_dev) dev_q <= rval;
    end
  end

  assign ram_req   = bus_req && !is_dev;
  assign ram_we    = bus_we;
  assign ram_addr  = bus_addr;
  assign ram_wdata = bus_wdata;
  assign bus_rdata = devrd_q ? dev_q : ram_rdata;
  assign run_en    = run_q;
endmodule

// File: rtl/conio_regs_chk.sv
module conio_regs_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] A_KS = 16'hFE00,
  parameter logic [AW-1:0] A_KD = 16'hFE02,
  parameter logic [AW-1:0] A_DS = 16'hFE04,
  parameter logic [AW-1:0] A_DD = 16'hFE06,
  parameter logic [AW-1:0] A_MC = 16'hFFFE
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          ram_req,
  input logic          disp_stb,
  input logic          run_en
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (run_en && !disp_stb));

  // R2
  dev_not_forwarded_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && (bus_addr == A_KS || bus_addr == A_KD || bus_addr == A_DS ||
                 bus_addr == A_DD || bus_addr == A_MC)) |-> !ram_req);

  // R8
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    disp_stb |=> !disp_stb);

  // R8
  stb_cause_chk: assert property (@(posedge clk) disable iff (rst)
    disp_stb |-> $past(bus_req && bus_we && bus_addr == A_DD));

  // R9
  run_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(run_en) |-> $past(bus_req && bus_we && bus_addr == A_MC));
endmodule

bind conio_regs conio_regs_chk #(
  .AW(AW), .A_KS(A_KS), .A_KD(A_KD), .A_DS(A_DS), .A_DD(A_DD), .A_MC(A_MC)
) u_chk (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .ram_req(ram_req), .disp_stb(disp_stb), .run_en(run_en)
);

// File: tb/sim_conio_regs.sv
module sim_conio_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ram_req, ram_we;
  logic [15:0] ram_addr, ram_wdata;
  logic [15:0] ram_rdata = '0;
  logic        key_stb = 1'b0;
  logic [7:0]  key_char = '0;
  logic        disp_ack = 1'b0;
  logic        disp_stb;
  logic [7:0]  disp_char;
  logic        run_en;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  conio_regs u0 (.*);

  logic [15:0] ram_mem [int];
  always @(posedge clk) begin
    if (ram_req) begin
      if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
      else ram_rdata <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 16'h0;
    end
  end

  bit         m_pv, m_dr, m_run;
  logic [7:0] m_pc, m_kd;
  logic [15:0] m_mem [int];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit req, input bit we, input logic [15:0] a, input logic [15:0] d,
                      input bit ks, input logic [7:0] kc, input bit ack, input string tag);
    bit dev, e_rd, e_stb;
    logic [15:0] e_val;
    logic [7:0]  e_chr;
    bus_req = req; bus_we = we; bus_addr = a; bus_wdata = d;
    key_stb = ks; key_char = kc; disp_ack = ack;
    dev = (a == 16'hFE00 || a == 16'hFE02 || a == 16'hFE04 || a == 16'hFE06 || a == 16'hFFFE);
    #1;
    // R2 pass-through
    chk("R2", {31'b0, ram_req}, {31'b0, req && !dev}, "ram_req");
    if (req && !dev) chk("R2", {ram_we, ram_addr, ram_wdata[14:0]}, {we, a, d[14:0]}, "ram fields");
    @(posedge clk);
    e_rd = req && !we; e_val = 16'h0; e_stb = 0; e_chr = 8'h0;
    if (e_rd) begin
      case (a)
        16'hFE00: begin e_val = m_pv ? 16'h8000 : 16'h0; if (m_pv) m_kd = m_pc; m_pv = 0; end
        16'hFE02: e_val = {8'h0, m_kd};
        16'hFE04: e_val = m_dr ? 16'h8000 : 16'h0;
        16'hFE06: e_val = 16'h0;
        16'hFFFE: e_val = m_run ? 16'h8000 : 16'h0;
        default:  e_val = m_mem.exists(int'(a)) ? m_mem[int'(a)] : 16'h0;
      endcase
    end
    if (ks && kc != 0) begin m_pv = 1; m_pc = kc; end
    if (req && we) begin
      if (a == 16'hFE06 && m_dr) begin e_stb = 1; e_chr = d[7:0]; end
      if (a == 16'hFFFE) m_run = d[15];
      if (!dev) m_mem[int'(a)] = d;
    end
    if (e_stb) m_dr = 0; else if (ack) m_dr = 1;
    @(negedge clk);
    if (e_rd) chk(tag, {16'h0, bus_rdata}, {16'h0, e_val}, "bus_rdata");
    chk(tag, {31'b0, disp_stb}, {31'b0, e_stb}, "disp_stb");
    if (e_stb) chk(tag, {24'h0, disp_char}, {24'h0, e_chr}, "disp_char");
    chk(tag, {31'b0, run_en}, {31'b0, m_run}, "run_en");
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(1, 0, a, 16'h0, 0, 8'h0, 0, tag);
  endtask
  task automatic wr(input logic [15:0] a, input logic [15:0] d, input string tag);
    step(1, 1, a, d, 0, 8'h0, 0, tag);
  endtask
  task automatic key(input logic [7:0] c, input string tag);
    step(0, 0, 16'h0, 16'h0, 1, c, 0, tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    m_pv = 0; m_dr = 1; m_run = 1; m_pc = 0; m_kd = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    chk("R1", {31'b0, run_en}, 32'd1, "run_en after reset");
    chk("R1", {31'b0, disp_stb}, 32'd0, "disp_stb after reset");
    rd(16'hFE00, "R1"); rd(16'hFE04, "R1"); rd(16'hFFFE, "R1");
    // R3 zero ignored, newest wins
    key(8'h00, "R3"); rd(16'hFE00, "R3");
    key(8'h41, "R3"); key(8'h42, "R3");
    rd(16'hFE00, "R4"); rd(16'hFE02, "R3");
    rd(16'hFE02, "R5");
    rd(16'hFE00, "R4");
    // R6 collision of strobe and status read
    key(8'h43, "R6");
    step(1, 0, 16'hFE00, 16'h0, 1, 8'h44, 0, "R6");
    rd(16'hFE02, "R6"); rd(16'hFE00, "R6"); rd(16'hFE02, "R6");
    // R10 ignored writes
    wr(16'hFE00, 16'hFFFF, "R10"); wr(16'hFE02, 16'h1234, "R10"); wr(16'hFE04, 16'h0000, "R10");
    rd(16'hFE02, "R10"); rd(16'hFE00, "R10"); rd(16'hFE04, "R10"); rd(16'hFE06, "R10");
    // R7 / R8 display handshake
    wr(16'hFE06, 16'h1255, "R8"); rd(16'hFE04, "R7");
    wr(16'hFE06, 16'h0066, "R8");
    step(0, 0, 16'h0, 16'h0, 0, 8'h0, 1, "R8"); rd(16'hFE04, "R7");
    step(1, 1, 16'hFE06, 16'h0077, 0, 8'h0, 1, "R8"); rd(16'hFE04, "R8");
    step(0, 0, 16'h0, 16'h0, 0, 8'h0, 1, "R8");
    // R9 run enable
    wr(16'hFFFE, 16'h7FFF, "R9"); rd(16'hFFFE, "R9");
    wr(16'hFFFE, 16'hFFFF, "R9"); rd(16'hFFFE, "R9");
    // R2 RAM pass-through and near misses
    wr(16'h3000, 16'hBEEF, "R2"); rd(16'h3000, "R2");
    wr(16'hFE01, 16'h5A5A, "R2"); rd(16'hFE01, "R2");
    wr(16'hFFFF, 16'hA5A5, "R2"); rd(16'hFFFF, "R2");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      case ($urandom_range(0, 7))
        0: a = 16'hFE00; 1: a = 16'hFE02; 2: a = 16'hFE04; 3: a = 16'hFE06;
        4: a = 16'hFFFE; 5: a = 16'hFE01; default: a = 16'h3000 + 16'($urandom_range(0, 7));
      endcase
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a,
           (a == 16'hFFFE && $urandom_range(0, 3) != 0) ? 16'h8000 : 16'($urandom),
           $urandom_range(0, 2) == 0, 8'($urandom_range(0, 3)), $urandom_range(0, 2) == 0, "R6");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule